// File: doc/BRIEF.md
# Single-Precision Divide Operand Fixup

This block is the front stage of an iterative single-precision divider. Each time the start strobe is high it takes a 32-bit IEEE-754 numerator and denominator. One clock later it presents a fixed-up numerator, a fixed-up denominator, a seed result word, an 8-bit adjust code, a normal-path flag and two one-cycle exception pulses: invalid and divide-by-zero.

Operand pairs that have a defined answer without any iteration are resolved here. These are NaNs, infinities and zeros. For them the stage writes the final value into the numerator slot, with 1.0 in the denominator and seed slots, or all-ones in every slot for an invalid result. Ordinary pairs take the normal path. The stage works out the biased quotient exponent and rescales both operands by 2^32 or 2^64, up or down, so that the later reciprocal iteration can neither overflow nor underflow. The adjust code tells the downstream logic which rescaling window was taken.

Scaling is done by rewriting the exponent field. Subnormal operands are first normalised with a leading-one search, so every scaled result is an exact normal number.

Top module: `fdiv_prescale`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the numerator, denominator and seed outputs are all 0xFFFFFFFF, the adjust code is 0 and the normal flag is 0. Invalid pulses exactly when some NaN operand has fraction bit 22 equal to 0.
- R2: If neither operand is a NaN, both being infinite or both being zero (of either sign) gives 0xFFFFFFFF on all three words and an invalid pulse.
- R3: A nonzero numerator over a zero denominator, including an infinite numerator, gives a numerator equal to infinity whose sign is the XOR of the operand signs. The denominator and seed become 1.0 (0x3F800000) and divide-by-zero pulses.
- R4: Otherwise, an infinite denominator, or a zero numerator over a finite nonzero denominator, gives a numerator of zero with the XOR sign, with the denominator and seed at 1.0 and no flag.
- R5: Otherwise, an infinite numerator over a finite nonzero denominator gives a numerator of infinity with the XOR sign, with the denominator and seed at 1.0 and no flag.
- R6: On the normal path, with nexp and dexp the biased exponent fields (1 for a subnormal), if nexp - dexp + 127 <= 23 the adjust code is 0x80, the numerator is scaled by 2^64 and the denominator by 2^-64.
- R7: On the normal path, if nexp - dexp + 127 > 230 the adjust code is 0x40, the numerator is scaled by 2^-32 and the denominator by 2^32.
- R8: If neither window of R6 or R7 applies, the first match in this order scales both operands, with an adjust code of 0: nexp <= 25 gives 2^64, then dexp <= 1 gives 2^32, then dexp > 252 gives 2^-32. If none matches, both operands pass through unchanged.
- R9: On the normal path the seed is 0, the normal flag is 1 and neither flag pulses. Every special case has the normal flag at 0.
- R10: Subnormal operands on the normal path are normalised before scaling, so the scaled value is exact and its exponent field lies strictly between 0 and 255.
- R11: Outputs are registered. They appear one cycle after the start strobe, together with a one-cycle valid pulse. The flags pulse only with valid. The data words hold until the next strobe. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start strobe: operands are sampled on this cycle |
| num_i | input | 32 | Numerator, IEEE-754 single |
| den_i | input | 32 | Denominator, IEEE-754 single |
| vld_o | output | 1 | One-cycle pulse: results are valid |
| num_o | output | 32 | Fixed-up numerator or special-case result |
| den_o | output | 32 | Fixed-up denominator |
| seed_o | output | 32 | Seed result word |
| adj_o | output | 8 | Adjust code: 0x80, 0x40 or 0 |
| norm_o | output | 1 | High when the operands need the iterative path |
| inv_o | output | 1 | Invalid-operation pulse |
| dbz_o | output | 1 | Divide-by-zero pulse |

## Verification
Several properties are checked on every cycle. The valid pulse follows each strobe by one cycle and the flags never appear without it. A normal-path result never carries a seed or a flag, and a nonzero adjust code is always one-hot and only on the normal path. Every scaled operand has an in-range exponent field. A divide-by-zero result is always a signed infinity over 1.0, and an invalid result is always all-ones. Only the bench's scenarios can show the exact values. These include the first-match order of the special cases (an infinite numerator over zero), each rescaling window and its secondary order, the exact normalisation of subnormals, and the XOR sign rules.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
   // Outcome of operand classification, in priority order
   typedef enum logic [2:0] {
      K_NAN  = 3'd0,   // all-ones result (NaN in, or invalid operation)
      K_DBZ  = 3'd1,   // nonzero over zero
      K_ZERO = 3'd2,   // signed zero result
      K_INF  = 3'd3,   // signed infinity result
      K_NORM = 3'd4    // ordinary operands, iterative path
   } fix_kind_t;

   localparam logic [7:0] ADJ_LOWQ  = 8'h80;
   localparam logic [7:0] ADJ_HIGHQ = 8'h40;
   localparam logic [7:0] ADJ_NONE  = 8'h00;
endpackage

// File: rtl/fdp_classify.sv
module fdp_classify
   import fdp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W-1:0] num_mag_i,
   input  logic [EXP_W+MAN_W-1:0] den_mag_i,
   output fix_kind_t              kind_o,
   output logic                   inv_o
);
   logic n_ones, d_ones, n_mnz, d_mnz, n_enz, d_enz;
   logic n_nan, d_nan, n_inf, d_inf, n_zero, d_zero;

   always_comb begin
      n_ones = &num_mag_i[EXP_W+MAN_W-1:MAN_W];
      d_ones = &den_mag_i[EXP_W+MAN_W-1:MAN_W];
      n_enz  = |num_mag_i[EXP_W+MAN_W-1:MAN_W];
      d_enz  = |den_mag_i[EXP_W+MAN_W-1:MAN_W];
      n_mnz  = |num_mag_i[MAN_W-1:0];
      d_mnz  = |den_mag_i[MAN_W-1:0];
      n_nan  = n_ones & n_mnz;
      d_nan  = d_ones & d_mnz;
      n_inf  = n_ones & ~n_mnz;
      d_inf  = d_ones & ~d_mnz;
      n_zero = ~n_enz & ~n_mnz;
      d_zero = ~d_enz & ~d_mnz;

      inv_o = 1'b0;
      if (n_nan || d_nan) begin
         kind_o = K_NAN;
         inv_o  = (n_nan && !num_mag_i[MAN_W-1]) || (d_nan && !den_mag_i[MAN_W-1]);
      end else if ((n_inf && d_inf) || (n_zero && d_zero)) begin
         kind_o = K_NAN;
         inv_o  = 1'b1;
      end else if (d_zero) begin
         kind_o = K_DBZ;
      end else if (d_inf || n_zero) begin
         kind_o = K_ZERO;
      end else if (n_inf) begin
         kind_o = K_INF;
      end else begin
         kind_o = K_NORM;
      end
   end
endmodule

// File: rtl/fdp_norm.sv
module fdp_norm #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int EW   = EXP_W + 3
) (
   input  logic [EXP_W+MAN_W-1:0] mag_i,
   output logic [EXP_W-1:0]       raw_exp_o,
   output logic signed [EW-1:0]   eff_exp_o,
   output logic [MAN_W-1:0]       frac_o
);
   logic [EXP_W-1:0] fld;
   logic [MAN_W-1:0] man;
   int               lead;

   assign fld = mag_i[EXP_W+MAN_W-1:MAN_W];
   assign man = mag_i[MAN_W-1:0];

   // Position of the leading one of a subnormal fraction
   always_comb begin
      lead = 0;
      for (int i = 0; i < MAN_W; i++)
         if (man[i]) lead = i;
   end

   always_comb begin
      if (fld != '0) begin
         raw_exp_o = fld;
         eff_exp_o = $signed({3'b000, fld});
         frac_o    = man;
      end else begin
         raw_exp_o = EXP_W'(1);
         eff_exp_o = EW'(lead) - EW'(MAN_W - 1);
         frac_o    = man << (MAN_W - lead);
      end
   end
endmodule

// File: rtl/fdp_scale.sv
module fdp_scale #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int EW   = EXP_W + 3
) (
   input  logic                    sign_i,
   input  logic signed [EW-1:0]    eff_exp_i,
   input  logic signed [EW-1:0]    shift_i,
   input  logic [MAN_W-1:0]        frac_i,
   output logic [EXP_W+MAN_W:0]    word_o,
   output logic                    bad_o
);
   localparam logic signed [EW-1:0] TOP_S = EW'((1 << EXP_W) - 1);

   logic signed [EW-1:0] sum;

   always_comb begin
      sum    = eff_exp_i + shift_i;
      bad_o  = (sum <= 0) || (sum >= TOP_S);
      word_o = {sign_i, sum[EXP_W-1:0], frac_i};
   end
endmodule

// File: rtl/fdiv_prescale.sv
module fdiv_prescale
   import fdp_pkg::*;
#(
   parameter int EXP_W    = 8,
   parameter int MAN_W    = 23,
   parameter int BIG_SH   = 64,
   parameter int SMALL_SH = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go_i,
   input  logic [EXP_W+MAN_W:0]   num_i,
   input  logic [EXP_W+MAN_W:0]   den_i,
   output logic                   vld_o,
   output logic [EXP_W+MAN_W:0]   num_o,
   output logic [EXP_W+MAN_W:0]   den_o,
   output logic [EXP_W+MAN_W:0]   seed_o,
   output logic [7:0]             adj_o,
   output logic                   norm_o,
   output logic                   inv_o,
   output logic                   dbz_o
);
   localparam int W      = 1 + EXP_W + MAN_W;
   localparam int EW     = EXP_W + 3;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int MAXEXP = (1 << EXP_W) - 2;
   localparam logic signed [EW-1:0] BIAS_S = EW'(BIAS);
   localparam logic signed [EW-1:0] LOQ_S  = EW'(MAN_W);
   localparam logic signed [EW-1:0] HIQ_S  = EW'(MAXEXP - (MAN_W + 1));
   localparam logic [EXP_W-1:0]     NSM    = EXP_W'(MAN_W + 2);
   localparam logic [EXP_W-1:0]     DSM    = EXP_W'(1);
   localparam logic [EXP_W-1:0]     DBG    = EXP_W'(MAXEXP - 2);
   localparam logic signed [EW-1:0] BIG_S  = EW'(BIG_SH);
   localparam logic signed [EW-1:0] SML_S  = EW'(SMALL_SH);
   localparam logic [W-1:0] ONE_W  = {1'b0, 1'b0, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};
   localparam logic [W-1:0] ALL1_W = '1;

   // Elaboration-time parameter checks
   if (EXP_W < 5 || EXP_W > 11) begin : g_bad_exp
      $error("EXP_W out of supported range");
   end
   if (MAN_W < 4) begin : g_bad_man
      $error("MAN_W too small");
   end
   if (SMALL_SH <= 0 || BIG_SH <= SMALL_SH || BIG_SH >= BIAS) begin : g_bad_sh
      $error("scale shifts must satisfy 0 < SMALL_SH < BIG_SH < bias");
   end

   fix_kind_t kind;
   logic      inv_n;
   logic      sx;

   fdp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .num_mag_i (num_i[W-2:0]),
      .den_mag_i (den_i[W-2:0]),
      .kind_o    (kind),
      .inv_o     (inv_n)
   );

   logic [EXP_W-1:0]     raw  [2];
   logic signed [EW-1:0] eff  [2];
   logic [MAN_W-1:0]     frac [2];
   logic signed [EW-1:0] sh   [2];
   logic [W-1:0]         scl  [2];
   logic                 bad  [2];

   for (genvar g = 0; g < 2; g++) begin : g_op
      logic [W-1:0] op;
      assign op = (g == 0) ? num_i : den_i;

      fdp_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
         .mag_i     (op[W-2:0]),
         .raw_exp_o (raw[g]),
         .eff_exp_o (eff[g]),
         .frac_o    (frac[g])
      );

      fdp_scale #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_scale (
         .sign_i    (op[W-1]),
         .eff_exp_i (eff[g]),
         .shift_i   (sh[g]),
         .frac_i    (frac[g]),
         .word_o    (scl[g]),
         .bad_o     (bad[g])
      );
   end

   // Rescaling window selection
   logic signed [EW-1:0] qexp;
   logic [7:0]           adj_n;

   always_comb begin
      qexp  = $signed({3'b000, raw[0]}) - $signed({3'b000, raw[1]}) + BIAS_S;
      adj_n = ADJ_NONE;
      sh[0] = '0;
      sh[1] = '0;
      if (qexp <= LOQ_S) begin
         adj_n = ADJ_LOWQ;
         sh[0] = BIG_S;
         sh[1] = -BIG_S;
      end else if (qexp > HIQ_S) begin
         adj_n = ADJ_HIGHQ;
         sh[0] = -SML_S;
         sh[1] = SML_S;
      end else if (raw[0] <= NSM) begin
         sh[0] = BIG_S;
         sh[1] = BIG_S;
      end else if (raw[1] <= DSM) begin
         sh[0] = SML_S;
         sh[1] = SML_S;
      end else if (raw[1] > DBG) begin
         sh[0] = -SML_S;
         sh[1] = -SML_S;
      end
   end

   // Result assembly
   logic [W-1:0] num_n, den_n, seed_n;
   logic         norm_n, dbz_n;

   assign sx = num_i[W-1] ^ den_i[W-1];

   always_comb begin
      num_n  = ALL1_W;
      den_n  = ONE_W;
      seed_n = ONE_W;
      norm_n = 1'b0;
      dbz_n  = 1'b0;
      unique case (kind)
         K_NAN: begin
            den_n  = ALL1_W;
            seed_n = ALL1_W;
         end
         K_DBZ: begin
            num_n = {sx, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            dbz_n = 1'b1;
         end
         K_ZERO: num_n = {sx, {(W-1){1'b0}}};
         K_INF:  num_n = {sx, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
         K_NORM: begin
            num_n  = scl[0];
            den_n  = scl[1];
            seed_n = '0;
            norm_n = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         num_o  <= '0;
         den_o  <= '0;
         seed_o <= '0;
         adj_o  <= '0;
         norm_o <= 1'b0;
         inv_o  <= 1'b0;
         dbz_o  <= 1'b0;
      end else begin
         vld_o <= go_i;
         inv_o <= go_i & inv_n;
         dbz_o <= go_i & dbz_n;
         if (go_i) begin
            num_o  <= num_n;
            den_o  <= den_n;
            seed_o <= seed_n;
            adj_o  <= norm_n ? adj_n : ADJ_NONE;
            norm_o <= norm_n;
         end
      end
   end

   // R11
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |=> vld_o);
   // R11
   flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_o || dbz_o) |-> vld_o);
   // R9
   norm_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && norm_o) |-> (seed_o == '0 && !inv_o && !dbz_o));
   // R6
   adj_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_o != '0) |-> (norm_o && $countones(adj_o) == 1));
   // R10
   exact_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && kind == K_NORM) |-> (!bad[0] && !bad[1]));
   // R3
   dbz_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbz_o |-> (den_o == ONE_W && seed_o == ONE_W && num_o[W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}} && !inv_o));
   // R2
   inv_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_o |-> (num_o == ALL1_W && den_o == ALL1_W && !norm_o));
endmodule

// File: tb/fdiv_prescale_bench.sv
module fdiv_prescale_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go_i = 1'b0;
   logic [31:0] num_i = '0, den_i = '0;
   logic        vld_o, norm_o, inv_o, dbz_o;
   logic [31:0] num_o, den_o, seed_o;
   logic [7:0]  adj_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fdiv_prescale u_fdiv_prescale (
      .clk(clk), .rst_n(rst_n), .go_i(go_i), .num_i(num_i), .den_i(den_i),
      .vld_o(vld_o), .num_o(num_o), .den_o(den_o), .seed_o(seed_o),
      .adj_o(adj_o), .norm_o(norm_o), .inv_o(inv_o), .dbz_o(dbz_o)
   );

   // {num, den, exp num, exp den, exp seed, exp adj, exp norm, exp inv, exp dbz}
   localparam int NV = 24;
   localparam logic [170:0] VEC [NV] = '{
      {32'h7FC00000, 32'h3F800000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b0, 1'b0},
      {32'h7F800001, 32'h3F800000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b1, 1'b0},
      {32'h3F800000, 32'hFF800001, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b1, 1'b0},
      {32'h7FC00000, 32'hFFC00000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b0, 1'b0},
      {32'h7FC00000, 32'h7F800001, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b1, 1'b0},
      {32'h7F800000, 32'hFF800000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b1, 1'b0},
      {32'h00000000, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b1, 1'b0},
      {32'hC0000000, 32'h00000000, 32'hFF800000, 32'h3F800000, 32'h3F800000, 8'h00, 1'b0, 1'b0, 1'b1},
      {32'h7F800000, 32'h80000000, 32'hFF800000, 32'h3F800000, 32'h3F800000, 8'h00, 1'b0, 1'b0, 1'b1},
      {32'h40400000, 32'hFF800000, 32'h80000000, 32'h3F800000, 32'h3F800000, 8'h00, 1'b0, 1'b0, 1'b0},
      {32'h80000000, 32'h40A00000, 32'h80000000, 32'h3F800000, 32'h3F800000, 8'h00, 1'b0, 1'b0, 1'b0},
      {32'h00000000, 32'h7F800000, 32'h00000000, 32'h3F800000, 32'h3F800000, 8'h00, 1'b0, 1'b0, 1'b0},
      {32'hFF800000, 32'h40000000, 32'hFF800000, 32'h3F800000, 32'h3F800000, 8'h00, 1'b0, 1'b0, 1'b0},
      {32'h3F800000, 32'h40000000, 32'h3F800000, 32'h40000000, 32'h00000000, 8'h00, 1'b1, 1'b0, 1'b0},
      {32'h3F800000, 32'h7D000000, 32'h5F800000, 32'h1D000000 | 32'h40000000, 32'h00000000, 8'h80, 1'b1, 1'b0, 1'b0},
      {32'h7D000000, 32'h3F800000, 32'h6D000000, 32'h4F800000, 32'h00000000, 8'h40, 1'b1, 1'b0, 1'b0},
      {32'h0A000000, 32'h32000000, 32'h2A000000, 32'h52000000, 32'h00000000, 8'h00, 1'b1, 1'b0, 1'b0},
      {32'h19000000, 32'h00800000, 32'h29000000, 32'h10800000, 32'h00000000, 8'h00, 1'b1, 1'b0, 1'b0},
      {32'h64000000, 32'h7E800000, 32'h54000000, 32'h6E800000, 32'h00000000, 8'h00, 1'b1, 1'b0, 1'b0},
      {32'h00000001, 32'h3F800000, 32'h15000000, 32'h1F800000, 32'h00000000, 8'h80, 1'b1, 1'b0, 1'b0},
      {32'h3F800000, 32'h00400000, 32'h2F800000, 32'h10000000, 32'h00000000, 8'h40, 1'b1, 1'b0, 1'b0},
      {32'h80000003, 32'h3F800000, 32'h95C00000, 32'h1F800000, 32'h00000000, 8'h80, 1'b1, 1'b0, 1'b0},
      {32'hBFC00000, 32'h40400000, 32'hBFC00000, 32'h40400000, 32'h00000000, 8'h00, 1'b1, 1'b0, 1'b0},
      {32'h0A000000, 32'h00800000, 32'h2A000000, 32'h20800000, 32'h00000000, 8'h00, 1'b1, 1'b0, 1'b0}
   };
   localparam string TAG [NV] = '{
      "R1", "R1", "R1", "R1", "R1", "R2", "R2", "R3", "R3", "R4", "R4", "R4",
      "R5", "R9", "R6", "R7", "R8", "R8", "R8", "R10", "R10", "R10", "R9", "R8"
   };

   task automatic check(input string req, input logic [106:0] got, input logic [106:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic apply(input logic [31:0] n, input logic [31:0] d);
      @(negedge clk);
      num_i = n;
      den_i = d;
      go_i  = 1'b1;
      @(negedge clk);
      go_i  = 1'b0;
   endtask

   function automatic logic [106:0] outs();
      return {num_o, den_o, seed_o, adj_o, norm_o, inv_o, dbz_o};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11", {vld_o, outs()} == '0 ? 107'd0 : 107'd1, 107'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", {106'd0, vld_o}, 107'd0);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][170:139], VEC[i][138:107]);
         check(TAG[i], outs(), VEC[i][106:0]);
         check("R11", {106'd0, vld_o}, 107'd1);
      end

      // R11: pulses last one cycle, data holds without a strobe
      apply(32'hC0000000, 32'h00000000);
      @(negedge clk);
      check("R11", {num_o, den_o, seed_o, adj_o, norm_o, vld_o, dbz_o},
            {32'hFF800000, 32'h3F800000, 32'h3F800000, 8'h00, 1'b0, 1'b0, 1'b0});

      // R11 / R2: back-to-back strobes, invalid pulse then clean result
      @(negedge clk);
      num_i = 32'h00000000; den_i = 32'h00000000; go_i = 1'b1;
      @(negedge clk);
      check("R2", outs(), {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b1, 1'b0});
      num_i = 32'h3F800000; den_i = 32'h40000000;
      @(negedge clk);
      go_i = 1'b0;
      check("R9", {vld_o, outs()} == {1'b1, 32'h3F800000, 32'h40000000, 32'h0, 8'h00, 1'b1, 1'b0, 1'b0}
            ? 107'd0 : 107'd1, 107'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R11: watchdog expired, got hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule